// File: doc/BRIEF.md
# Machine Status Register with Configurable Fields

This block holds the machine-level status control register of a hart. Elaboration parameters choose the native register width (32, 64 or 128), whether user and supervisor privilege levels exist, whether page-based address translation exists, and whether the hart boots big-endian. These parameters decide two things: the value the register takes at reset, and which of its bits software may change.

A CSR write updates only the bits that the configuration allows to change. All other bits keep their value. The block also checks accesses to the address-translation register. It raises an illegal-access flag, in the same cycle, when the current privilege level may not touch that register, given the trap-virtual-memory bit held here.

Privilege levels are encoded as 0 for user, 1 for supervisor and 3 for machine. The value 2 is treated as a level below machine.

Top module: `mstatus_unit`

## Requirements
- R1: At reset, bits 33:32 (user width code) hold the width code only when user mode exists and the width is not 32. Otherwise they hold 0. The code is 1 for 32, 2 for 64 and 3 for 128.
- R2: At reset, bits 35:34 (supervisor width code) hold the width code only when supervisor mode exists and the width is not 32. Otherwise they hold 0.
- R3: With the big-endian parameter set, bit 37 (machine endianness) resets to 1. Bit 6 (user endianness) resets to 1 only if user mode exists, and bit 36 (supervisor endianness) resets to 1 only if supervisor mode exists. A little-endian configuration resets all three to 0, and every other bit resets to 0.
- R4: Bits 3, 7, 12:11 and 21 are always writable. A write changes the output at the clock edge that samples the write strobe.
- R5: Bit 17 (modify-privilege) is writable only when user mode exists. Otherwise it stays 0.
- R6: Bit 22 (trap-return-from-supervisor) is writable only when supervisor mode exists. Otherwise it stays 0.
- R7: Bit 20 (trap-virtual-memory) is writable only when paging exists. Otherwise it stays 0.
- R8: A write leaves all bits outside the writable set unchanged, and the register keeps its value in any cycle without a write.
- R9: While bit 20 is 1, a translation-register access is legal only from privilege 3. Any other privilege raises the illegal flag.
- R10: While bit 20 is 0, an access is legal from privilege 1 or 3 and illegal from 0 or 2. The flag is combinational and stays 0 when no access is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| priv_i | input | 2 | Current privilege level |
| wr_en_i | input | 1 | CSR write strobe |
| wr_data_i | input | 64 | CSR write data |
| satp_acc_i | input | 1 | Access strobe for the translation register |
| status_o | output | 64 | Current register value |
| satp_illegal_o | output | 1 | Illegal translation-register access |

## Verification
The hardest case to reach is the gating of fields by configuration. A bit that never moves looks the same as a bit that was written 0, so the bench runs four instances with different parameter sets from the same stimulus. It then writes all ones and all zeros and compares each instance against its own expected mask. The illegal-access check under a set trap bit can only be reached after software has written that bit. The bench therefore writes it first, then sweeps all four privilege codes. It also confirms that an instance without paging keeps supervisor access legal after the same write.

// File: rtl/mstatus_pkg.sv
package mstatus_pkg;
    localparam int STATUS_W = 64;

    localparam int BIT_MIE  = 3;
    localparam int BIT_UBE  = 6;
    localparam int BIT_MPIE = 7;
    localparam int BIT_MPP0 = 11;
    localparam int BIT_MPP1 = 12;
    localparam int BIT_MPRV = 17;
    localparam int BIT_TVM  = 20;
    localparam int BIT_TW   = 21;
    localparam int BIT_TSR  = 22;
    localparam int BIT_UXL  = 32;
    localparam int BIT_SXL  = 34;
    localparam int BIT_SBE  = 36;
    localparam int BIT_MBE  = 37;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic [STATUS_W-1:0] status;
    } state_t;

    function automatic logic [1:0] width_code(input int xlen);
        case (xlen)
            32:      return 2'd1;
            64:      return 2'd2;
            128:     return 2'd3;
            default: return 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/mstatus_reset_gen.sv
module mstatus_reset_gen
    import mstatus_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit HAS_U      = 1'b1,
    parameter bit HAS_S      = 1'b1,
    parameter bit BIG_ENDIAN = 1'b0
) (
    output logic [STATUS_W-1:0] rst_val_o
);
    localparam logic [1:0] WCODE = width_code(XLEN);
    localparam bit WIDE = (XLEN != 32);

    logic [1:0] uxl_val;
    logic [1:0] sxl_val;

    generate
        if (HAS_U && WIDE) begin : g_uxl
            assign uxl_val = WCODE;
        end else begin : g_no_uxl
            assign uxl_val = 2'd0;
        end
        if (HAS_S && WIDE) begin : g_sxl
            assign sxl_val = WCODE;
        end else begin : g_no_sxl
            assign sxl_val = 2'd0;
        end
    endgenerate

    always_comb begin
        rst_val_o = '0;
        rst_val_o[BIT_UXL +: 2] = uxl_val;
        rst_val_o[BIT_SXL +: 2] = sxl_val;
        rst_val_o[BIT_MBE] = BIG_ENDIAN;
        rst_val_o[BIT_UBE] = BIG_ENDIAN && HAS_U;
        rst_val_o[BIT_SBE] = BIG_ENDIAN && HAS_S;
    end
endmodule

// File: rtl/mstatus_wmask_gen.sv
module mstatus_wmask_gen
    import mstatus_pkg::*;
#(
    parameter bit HAS_U      = 1'b1,
    parameter bit HAS_S      = 1'b1,
    parameter bit HAS_PAGING = 1'b1
) (
    output logic [STATUS_W-1:0] wmask_o
);
    always_comb begin
        wmask_o = '0;
        wmask_o[BIT_MIE]  = 1'b1;
        wmask_o[BIT_MPIE] = 1'b1;
        wmask_o[BIT_MPP0] = 1'b1;
        wmask_o[BIT_MPP1] = 1'b1;
        wmask_o[BIT_TW]   = 1'b1;
        wmask_o[BIT_MPRV] = HAS_U;
        wmask_o[BIT_TSR]  = HAS_S;
        wmask_o[BIT_TVM]  = HAS_PAGING;
    end
endmodule

// File: rtl/mstatus_satp_guard.sv
module mstatus_satp_guard
    import mstatus_pkg::*;
(
    input  logic [1:0] priv_i,
    input  logic       tvm_i,
    input  logic       acc_i,
    output logic       illegal_o
);
    logic allowed;

    always_comb begin
        if (tvm_i) begin
            allowed = (priv_i == PRIV_MACH);
        end else begin
            allowed = (priv_i == PRIV_MACH) || (priv_i == PRIV_SUPER);
        end
        illegal_o = acc_i && !allowed;
    end
endmodule

// File: rtl/mstatus_unit.sv
module mstatus_unit
    import mstatus_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter bit HAS_U      = 1'b1,
    parameter bit HAS_S      = 1'b1,
    parameter bit HAS_PAGING = 1'b1,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          priv_i,
    input  logic                wr_en_i,
    input  logic [STATUS_W-1:0] wr_data_i,
    input  logic                satp_acc_i,
    output logic [STATUS_W-1:0] status_o,
    output logic                satp_illegal_o
);
    logic [STATUS_W-1:0] rst_val;
    logic [STATUS_W-1:0] wmask;
    state_t              st_d;
    state_t              st_q;

    mstatus_reset_gen #(
        .XLEN       (XLEN),
        .HAS_U      (HAS_U),
        .HAS_S      (HAS_S),
        .BIG_ENDIAN (BIG_ENDIAN)
    ) u_reset_gen (
        .rst_val_o (rst_val)
    );

    mstatus_wmask_gen #(
        .HAS_U      (HAS_U),
        .HAS_S      (HAS_S),
        .HAS_PAGING (HAS_PAGING)
    ) u_wmask_gen (
        .wmask_o (wmask)
    );

    mstatus_satp_guard u_satp_guard (
        .priv_i    (priv_i),
        .tvm_i     (st_q.status[BIT_TVM]),
        .acc_i     (satp_acc_i),
        .illegal_o (satp_illegal_o)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.status = (st_q.status & ~wmask) | (wr_data_i & wmask);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.status <= rst_val;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o = st_q.status;
endmodule

// File: rtl/mstatus_unit_sva.sv
module mstatus_unit_sva #(
    parameter bit HAS_U      = 1'b1,
    parameter bit HAS_S      = 1'b1,
    parameter bit HAS_PAGING = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  priv_i,
    input logic        wr_en_i,
    input logic [63:0] wr_data_i,
    input logic        satp_acc_i,
    input logic [63:0] status_o,
    input logic        satp_illegal_o
);
    localparam logic [63:0] CHK_MASK = 64'h0000_0000_0020_1888
        | (HAS_U      ? 64'h0000_0000_0002_0000 : 64'h0)
        | (HAS_S      ? 64'h0000_0000_0040_0000 : 64'h0)
        | (HAS_PAGING ? 64'h0000_0000_0010_0000 : 64'h0);

    p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> ((status_o & CHK_MASK) == ($past(wr_data_i) & CHK_MASK)));

    p_fixed_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_o & ~CHK_MASK) == ($past(status_o) & ~CHK_MASK)));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(status_o));

    p_tvm_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (satp_acc_i && status_o[20] && priv_i != 2'd3) |-> satp_illegal_o);

    p_machine_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (satp_acc_i && priv_i == 2'd3) |-> !satp_illegal_o);

    p_user_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (satp_acc_i && priv_i == 2'd0) |-> satp_illegal_o);

    p_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !satp_acc_i |-> !satp_illegal_o);

    p_mprv_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_U |-> !status_o[17]);

    p_tsr_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_S |-> !status_o[22]);

    p_tvm_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !HAS_PAGING |-> !status_o[20]);
endmodule

bind mstatus_unit mstatus_unit_sva #(
    .HAS_U      (HAS_U),
    .HAS_S      (HAS_S),
    .HAS_PAGING (HAS_PAGING)
) u_sva (
    .clk            (clk),
    .rst_n          (rst_n),
    .priv_i         (priv_i),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .satp_acc_i     (satp_acc_i),
    .status_o       (status_o),
    .satp_illegal_o (satp_illegal_o)
);

// File: tb/mstatus_unit_bench.sv
module mstatus_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  priv = 2'd3;
    logic        wr_en = 1'b0;
    logic [63:0] wd = '0;
    logic        acc = 1'b0;
    logic [63:0] st [4];
    logic        ill [4];

    always #10 clk = ~clk;

    // Config 0: 64-bit, U, S, paging, little-endian
    // Config 1: 64-bit, no U, no S, no paging, big-endian
    // Config 2: 32-bit, U, S, paging, big-endian
    // Config 3: 128-bit, U, S, paging, little-endian
    mstatus_unit u_mstatus_unit (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .wr_en_i(wr_en), .wr_data_i(wd),
        .satp_acc_i(acc), .status_o(st[0]), .satp_illegal_o(ill[0]));
    mstatus_unit #(.XLEN(64), .HAS_U(1'b0), .HAS_S(1'b0), .HAS_PAGING(1'b0), .BIG_ENDIAN(1'b1)) u_mstatus_unit_min (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .wr_en_i(wr_en), .wr_data_i(wd),
        .satp_acc_i(acc), .status_o(st[1]), .satp_illegal_o(ill[1]));
    mstatus_unit #(.XLEN(32), .HAS_U(1'b1), .HAS_S(1'b1), .HAS_PAGING(1'b1), .BIG_ENDIAN(1'b1)) u_mstatus_unit_rv32 (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .wr_en_i(wr_en), .wr_data_i(wd),
        .satp_acc_i(acc), .status_o(st[2]), .satp_illegal_o(ill[2]));
    mstatus_unit #(.XLEN(128), .HAS_U(1'b1), .HAS_S(1'b1), .HAS_PAGING(1'b1), .BIG_ENDIAN(1'b0)) u_mstatus_unit_wide (
        .clk(clk), .rst_n(rst_n), .priv_i(priv), .wr_en_i(wr_en), .wr_data_i(wd),
        .satp_acc_i(acc), .status_o(st[3]), .satp_illegal_o(ill[3]));

    // Expected reset values and writable masks, worked out from R1..R7
    localparam logic [63:0] RST [4] = '{64'h0000_000A_0000_0000, 64'h0000_0020_0000_0000,
                                        64'h0000_0030_0000_0040, 64'h0000_000F_0000_0000};
    localparam logic [63:0] MSK [4] = '{64'h0000_0000_0072_1888, 64'h0000_0000_0020_1888,
                                        64'h0000_0000_0072_1888, 64'h0000_0000_0072_1888};

    typedef struct {
        int          due;
        int          dut;
        logic [63:0] exp;
        string       tag;
    } item_t;

    item_t       sb_q [$];
    logic [63:0] model [4];
    int          cyc = 0;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops items whose result cycle has arrived
    always @(negedge clk) begin
        while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
            item_t it;
            it = sb_q.pop_front();
            check(it.tag, st[it.dut], it.exp);
        end
    end

    task automatic drive_write(input logic [63:0] v, input string tag);
        @(negedge clk);
        wr_en = 1'b1;
        wd = v;
        for (int d = 0; d < 4; d++) begin
            model[d] = (model[d] & ~MSK[d]) | (v & MSK[d]);
            sb_q.push_back('{cyc + 1, d, model[d], tag});
        end
        @(negedge clk);
        wr_en = 1'b0;
        wd = ~v;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wd = {$urandom, $urandom};
            for (int d = 0; d < 4; d++) sb_q.push_back('{cyc + 1, d, model[d], "R8 idle hold"});
        end
    endtask

    task automatic probe(input int d, input logic [1:0] p, input logic exp, input string tag);
        @(negedge clk);
        priv = p;
        acc = 1'b1;
        #1;
        check(tag, {63'd0, ill[d]}, {63'd0, exp});
        acc = 1'b0;
        #1;
        check("R10 no strobe", {63'd0, ill[d]}, 64'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 4; d++) model[d] = RST[d];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset values
        check("R1 uxl 64", {62'd0, st[0][33:32]}, 64'd2);
        check("R1 uxl absent", {62'd0, st[1][33:32]}, 64'd0);
        check("R1 uxl rv32", {62'd0, st[2][33:32]}, 64'd0);
        check("R1 uxl 128", {62'd0, st[3][33:32]}, 64'd3);
        check("R2 sxl 64", {62'd0, st[0][35:34]}, 64'd2);
        check("R2 sxl absent", {62'd0, st[1][35:34]}, 64'd0);
        check("R2 sxl 128", {62'd0, st[3][35:34]}, 64'd3);
        for (int d = 0; d < 4; d++) check("R3 reset value", st[d], RST[d]);

        // All ones
        drive_write('1, "R4 write ones");
        repeat (2) @(negedge clk);
        check("R4 mpp", {62'd0, st[0][12:11]}, 64'd3);
        check("R5 mprv with U", {63'd0, st[0][17]}, 64'd1);
        check("R5 mprv without U", {63'd0, st[1][17]}, 64'd0);
        check("R6 tsr with S", {63'd0, st[0][22]}, 64'd1);
        check("R6 tsr without S", {63'd0, st[1][22]}, 64'd0);
        check("R7 tvm with paging", {63'd0, st[0][20]}, 64'd1);
        check("R7 tvm without paging", {63'd0, st[1][20]}, 64'd0);
        check("R8 ube kept", {63'd0, st[2][6]}, 64'd1);

        // Trap bit set on config 0
        probe(0, 2'd0, 1'b1, "R9 user under tvm");
        probe(0, 2'd1, 1'b1, "R9 super under tvm");
        probe(0, 2'd2, 1'b1, "R9 reserved under tvm");
        probe(0, 2'd3, 1'b0, "R9 machine under tvm");
        probe(1, 2'd1, 1'b0, "R7 no paging keeps super legal");

        // All zeros
        drive_write('0, "R8 write zeros");
        repeat (2) @(negedge clk);
        probe(0, 2'd0, 1'b1, "R10 user");
        probe(0, 2'd1, 1'b0, "R10 super");
        probe(0, 2'd2, 1'b1, "R10 reserved");
        probe(0, 2'd3, 1'b0, "R10 machine");

        drive_write(64'hAAAA_5555_F0F0_0F0F, "R4 pattern a");
        drive_write(64'h5555_AAAA_0F0F_F0F0, "R4 pattern b");
        idle(3);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule